// File: doc/BRIEF.md
# Power-On Configuration Boot Sequencer

After a power-on reset this block copies a fixed, contiguous window of words from a nonvolatile configuration store into the matching locations of its own register bank. It issues one read per cycle on a simple memory port with one cycle of read latency. It writes each returned word back on the cycle the data arrives. The low part of the bank, which holds the converter output settings, is never loaded from the store and stays at its reset value of zero.

While the copy runs, the rest of the system is held quiet. The host register port ignores writes and reads back zero. Channel faults are masked. The output enable for the general-purpose, converter and enable pins is low, so those pins are high-impedance. The supervisory reset output is held low.

Once the last word is in place, a done flag rises and normal operation is released. The reset output is then released only after every monitored channel has stayed in range for a timeout. That timeout is read from a copied configuration register. If any channel drops out of range, the timeout count starts again from zero.

Top module: `boot_seq_top`

## Requirements
- R1: Starting in the first cycle after the first clock edge that sees `rst` low, `nv_rd` is high for exactly 111 consecutive cycles, and `nv_addr` steps by one from 0x0F up to 0x7D. At all other times `nv_rd` is low.
- R2: After boot, every bank address in 0x0F..0x7D holds the word the store returned for that address. The store returns data one cycle after the address is presented.
- R3: After boot, bank addresses 0x00..0x0E, 0x7E and 0x7F read zero. Addresses 0x00..0x0B are the converter output settings and are never written by the copy.
- R4: `boot_done` is low in reset. It goes high in the cycle after the last word is written, which is 113 clock edges after reset is released counting the first edge that sees `rst` low. It then stays high until the next reset.
- R5: While `boot_done` is low, `host_ready` is low, `host_rdata` reads zero and a host write has no effect. After boot, a write on `host_we` lands at the clock edge, and `host_rdata` shows `host_addr`'s content combinationally.
- R6: `flt_out` is all zero while `boot_done` is low and equals `flt_raw` afterwards.
- R7: `out_oe` is low (outputs high-impedance) in reset and during boot, and high once `boot_done` is high.
- R8: `rst_n_out` is low in reset and during boot. With T the value of bank address 0x0F, `rst_n_out` rises T+1 clock edges after the start of the first cycle in which `boot_done` is high and every bit of `ch_ok` is 1.
- R9: Any `ch_ok` bit at 0 restarts the timeout count from zero. If `rst_n_out` was already high, it falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| nv_rd | output | 1 | Read strobe to the configuration store |
| nv_addr | output | 7 | Read address to the configuration store |
| nv_rdata | input | 8 | Store data, valid one cycle after the address |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (zero during boot) |
| host_ready | output | 1 | Host access allowed |
| ch_ok | input | 12 | Per-channel in-range flags |
| flt_raw | input | 12 | Per-channel raw fault flags |
| flt_out | output | 12 | Fault flags after boot masking |
| out_oe | output | 1 | Output enable for general, converter and enable pins |
| rst_n_out | output | 1 | Active-low supervisory reset output |
| boot_done | output | 1 | Boot copy complete |

## Verification
The read strobe and address are due in the cycle after the first edge with reset low. The done flag is due 113 edges after that edge, and the reset release T+1 edges after the first cycle in which done and all channels in range hold together; a drop of the reset output is due one edge after a channel leaves range. The bench drives every input on the falling edge and samples there too, counting falling edges from the stimulus, so each comparison lands in the exact cycle the result is due. It checks for equality at that cycle, not for "eventually". Host reads are combinational and are sampled one nanosecond after the address is driven, and host writes are read back one edge later.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam int AW      = 7;
    localparam int DW      = 8;
    localparam int NCH_DEF = 12;
    localparam int DEPTH   = 1 << AW;

    localparam logic [AW-1:0] CP_FIRST = 7'h0F;
    localparam logic [AW-1:0] CP_LAST  = 7'h7D;
    localparam logic [AW-1:0] TMO_ADDR = 7'h0F;

    typedef enum logic [1:0] {
        ST_START,
        ST_COPY,
        ST_DRAIN,
        ST_DONE
    } boot_st_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cfg_wr_t;

    function automatic logic in_copy_span(logic [AW-1:0] a);
        return (a >= CP_FIRST) && (a <= CP_LAST);
    endfunction
endpackage

// File: rtl/boot_copy_seq.sv
module boot_copy_seq
    import boot_pkg::*;
#(
    parameter logic [AW-1:0] FIRST = CP_FIRST,
    parameter logic [AW-1:0] LAST  = CP_LAST
) (
    input  logic          clk,
    input  logic          rst,
    output logic          nv_rd,
    output logic [AW-1:0] nv_addr,
    input  logic [DW-1:0] nv_rdata,
    output cfg_wr_t       wr,
    output logic          done
);
    boot_st_e      state;
    logic [AW-1:0] rd_addr;
    logic          wr_vld;
    logic [AW-1:0] wr_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_START;
            rd_addr <= FIRST;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            done    <= 1'b0;
        end else begin
            wr_vld  <= (state == ST_COPY);
            wr_addr <= rd_addr;
            unique case (state)
                ST_START: state <= ST_COPY;
                ST_COPY: begin
                    if (rd_addr == LAST) state <= ST_DRAIN;
                    else                 rd_addr <= rd_addr + 1'b1;
                end
                ST_DRAIN: begin
                    state <= ST_DONE;
                    done  <= 1'b1;
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    assign nv_rd   = (state == ST_COPY);
    assign nv_addr = rd_addr;

    always_comb begin
        wr.vld  = wr_vld;
        wr.addr = wr_addr;
        wr.data = nv_rdata;
    end

    // R1: consecutive reads walk upward by one
    a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
        (nv_rd && $past(nv_rd)) |-> (nv_addr == $past(nv_addr) + 1'b1));
    // R1: reads stay inside the copy window
    a_r1_addr_span: assert property (@(posedge clk) disable iff (rst)
        nv_rd |-> in_copy_span(nv_addr));
    // R2: a write-back follows a read one cycle earlier at the same address
    a_r2_wr_follows: assert property (@(posedge clk) disable iff (rst)
        wr.vld |-> ($past(nv_rd) && (wr.addr == $past(nv_addr))));
    // R4: done never falls outside reset
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> done);
endmodule

// File: rtl/boot_regbank.sv
module boot_regbank
    import boot_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_wr_t       cp_wr,
    input  logic          host_ok,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] tmo_val
);
    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (cp_wr.vld) begin
            regs[cp_wr.addr] <= cp_wr.data;
        end else if (host_ok && host_we) begin
            regs[host_addr] <= host_wdata;
        end
    end

    assign host_rdata = host_ok ? regs[host_addr] : '0;
    assign tmo_val    = regs[TMO_ADDR];

    // R3: copy never targets the uncopied low registers
    a_r3_copy_low: assert property (@(posedge clk) disable iff (rst)
        cp_wr.vld |-> in_copy_span(cp_wr.addr));

    for (genvar g = 0; g < int'(CP_FIRST); g++) begin : g_low_chk
        // R3/R5: low registers stay zero while the host is locked out
        a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
            !host_ok |-> (regs[g] == '0));
    end
endmodule

// File: rtl/boot_rst_timer.sv
module boot_rst_timer #(
    parameter int NCH = 12,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           done,
    input  logic [NCH-1:0] ch_ok,
    input  logic [CW-1:0]  tmo,
    output logic           rst_rel
);
    logic [CW-1:0] cnt;
    logic          all_ok;

    assign all_ok = &ch_ok;

    always_ff @(posedge clk) begin
        if (rst || !done || !all_ok) begin
            cnt     <= '0;
            rst_rel <= 1'b0;
        end else if (!rst_rel) begin
            if (cnt == tmo) rst_rel <= 1'b1;
            else            cnt <= cnt + 1'b1;
        end
    end

    // R8: reset output held during boot
    a_r8_hold_boot: assert property (@(posedge clk) disable iff (rst)
        !done |-> !rst_rel);
    // R8: release only follows a cycle of boot done with all channels good
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_rel) |-> ($past(done) && $past(all_ok)));
    // R9: any channel out of range pulls the release down next cycle
    a_r9_drop: assert property (@(posedge clk) disable iff (rst)
        !all_ok |=> !rst_rel);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_pkg::*;
#(
    parameter int NCH = NCH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    output logic           nv_rd,
    output logic [AW-1:0]  nv_addr,
    input  logic [DW-1:0]  nv_rdata,
    input  logic           host_we,
    input  logic [AW-1:0]  host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           host_ready,
    input  logic [NCH-1:0] ch_ok,
    input  logic [NCH-1:0] flt_raw,
    output logic [NCH-1:0] flt_out,
    output logic           out_oe,
    output logic           rst_n_out,
    output logic           boot_done
);
    cfg_wr_t       cp_wr;
    logic [DW-1:0] tmo_val;
    logic          rst_rel;

    boot_copy_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .nv_rd    (nv_rd),
        .nv_addr  (nv_addr),
        .nv_rdata (nv_rdata),
        .wr       (cp_wr),
        .done     (boot_done)
    );

    boot_regbank u_bank (
        .clk        (clk),
        .rst        (rst),
        .cp_wr      (cp_wr),
        .host_ok    (boot_done),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tmo_val    (tmo_val)
    );

    boot_rst_timer #(.NCH(NCH), .CW(DW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .done    (boot_done),
        .ch_ok   (ch_ok),
        .tmo     (tmo_val),
        .rst_rel (rst_rel)
    );

    assign host_ready = boot_done;
    assign flt_out    = flt_raw & {NCH{boot_done}};
    assign out_oe     = boot_done;
    assign rst_n_out  = rst_rel;

    // R6: no fault reaches the output while the store copy is running
    a_r6_mask: assert property (@(posedge clk) disable iff (rst)
        nv_rd |-> (flt_out == '0));
    // R7: outputs stay disabled while reads are in flight
    a_r7_oe_off: assert property (@(posedge clk) disable iff (rst)
        nv_rd |-> !out_oe);
    // R5: host port locked while copy reads are issued
    a_r5_locked: assert property (@(posedge clk) disable iff (rst)
        nv_rd |-> (!host_ready && host_rdata == '0));
endmodule

// File: tb/boot_seq_top_test.sv
`timescale 1ns/1ps
module boot_seq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nv_rd;
    logic [6:0]  nv_addr;
    logic [7:0]  nv_rdata = '0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [11:0] ch_ok = '1;
    logic [11:0] flt_raw = 12'hABC;
    logic [11:0] flt_out;
    logic        out_oe;
    logic        rst_n_out;
    logic        boot_done;

    logic [7:0]  nvm [128];
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    boot_seq_top uut (
        .clk(clk), .rst(rst), .nv_rd(nv_rd), .nv_addr(nv_addr),
        .nv_rdata(nv_rdata), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .ch_ok(ch_ok), .flt_raw(flt_raw),
        .flt_out(flt_out), .out_oe(out_oe), .rst_n_out(rst_n_out),
        .boot_done(boot_done)
    );

    // store model: data one cycle after address
    always @(posedge clk) if (nv_rd) nv_rdata <= nvm[nv_addr];

    // {we, addr, wdata, expected read}
    localparam logic [23:0] VEC [8] = '{
        {1'b1, 7'h00, 8'hA5, 8'hA5},
        {1'b1, 7'h0B, 8'h3C, 8'h3C},
        {1'b1, 7'h7F, 8'hFF, 8'hFF},
        {1'b1, 7'h40, 8'h12, 8'h12},
        {1'b0, 7'h7E, 8'h00, 8'h00},
        {1'b0, 7'h05, 8'h00, 8'h00},
        {1'b0, 7'h0C, 8'h00, 8'h00},
        {1'b1, 7'h0E, 8'h77, 8'h77}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input int a, input int t);
        if (a == 'h0F) return 8'(t);
        return 8'(a * 29 + 7);
    endfunction

    task automatic do_reset(input int t, input logic [11:0] ok);
        for (int a = 0; a < 128; a++) nvm[a] = exp_word(a, t);
        @(negedge clk);
        rst = 1'b1;
        ch_ok = ok;
        repeat (3) @(negedge clk);
        chk("R4 reset done", boot_done, 0);
        chk("R7 reset oe", out_oe, 0);
        chk("R8 reset rst_n", rst_n_out, 0);
        chk("R1 reset nv_rd", nv_rd, 0);
        rst = 1'b0;
    endtask

    task automatic wait_rel(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_n_out && n < 200);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        int bad_r1, bad_r4, bad_r6, bad_r7, bad_r8;
        bad_r1 = 0; bad_r4 = 0; bad_r6 = 0; bad_r7 = 0; bad_r8 = 0;

        // Phase A: timeout 5, channels good from the start
        do_reset(5, '1);
        for (int j = 1; j <= 125; j++) begin
            @(negedge clk);
            if (nv_rd !== (j >= 1 && j <= 111)) bad_r1++;
            if (nv_rd && nv_addr !== 7'(15 + j - 1)) bad_r1++;
            if (boot_done !== (j >= 113) || host_ready !== (j >= 113)) bad_r4++;
            if (flt_out !== ((j >= 113) ? flt_raw : 12'h000)) bad_r6++;
            if (out_oe !== (j >= 113)) bad_r7++;
            if (rst_n_out !== (j >= 119)) bad_r8++;
            if (j == 40) begin
                host_we = 1'b1; host_addr = 7'h05; host_wdata = 8'h99;
            end
            if (j == 41) host_we = 1'b0;
            if (j == 50) begin
                host_addr = 7'h20;
                #1 chk("R5 read blocked in boot", host_rdata, 0);
            end
        end
        chk("R1 read strobe and address walk", bad_r1, 0);
        chk("R4 done timing and hold", bad_r4, 0);
        chk("R6 fault mask", bad_r6, 0);
        chk("R7 output enable", bad_r7, 0);
        chk("R8 release at T+1 after done", bad_r8, 0);

        // full bank scan
        begin
            int bad2, bad3;
            bad2 = 0; bad3 = 0;
            for (int a = 0; a < 128; a++) begin
                host_addr = 7'(a);
                #0.1;
                if (a >= 'h0F && a <= 'h7D) begin
                    if (host_rdata !== exp_word(a, 5)) bad2++;
                end else if (host_rdata !== 8'h00) bad3++;
            end
            chk("R2 copied words", bad2, 0);
            chk("R3 uncopied words zero", bad3, 0);
        end

        // vector table walk of host access after boot
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            host_we = VEC[v][23]; host_addr = VEC[v][22:16]; host_wdata = VEC[v][15:8];
            @(negedge clk);
            host_we = 1'b0;
            #1 chk("R5 host access after boot", host_rdata, {24'h0, VEC[v][7:0]});
        end

        // R9 drop after release, then full restart
        @(negedge clk);
        ch_ok = 12'hFF7;
        @(negedge clk);
        chk("R9 drop after release", rst_n_out, 0);
        ch_ok = '1;
        wait_rel(n);
        chk("R9 re-release after T+1", n, 6);

        // Phase B: timeout 20, channels bad through boot, glitch before expiry
        do_reset(20, 12'h000);
        n = 0;
        while (!boot_done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R4 done edge count B", n, 113);
        repeat (10) @(negedge clk);
        chk("R8 held while channels out", rst_n_out, 0);
        ch_ok = '1;
        repeat (8) @(negedge clk);
        chk("R8 held before timeout", rst_n_out, 0);
        ch_ok = 12'hFFE;
        @(negedge clk);
        ch_ok = '1;
        wait_rel(n);
        chk("R9 count restarts after glitch", n, 21);

        // Phase C: timeout 0
        do_reset(0, '1);
        n = 0;
        while (!boot_done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R8 zero timeout not yet", rst_n_out, 0);
        wait_rel(n);
        chk("R8 zero timeout one edge", n, 1);
        chk("R6 faults pass after boot", flt_out, flt_raw);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule